// File: doc/BRIEF.md
# Reversible Full-Period LFSR Address Generator

This block produces memory addresses for a built-in self-test engine. It is a shift register with external XOR feedback. The feedback polynomial and the starting value are loaded at run time. The plain feedback function is corrected by one extra term, so the sequence reaches every one of the 2^W addresses, all-zero included. Without that term the all-zero state would be skipped.

Each step runs forward or backward. A backward step is the exact inverse of a forward step. An ascending march element can therefore walk the forward sequence, and a descending element can retrace the same addresses in reverse order. A one-cycle wrap pulse marks the step that brings the address back to the value last loaded.

The control is a two-state machine:
- ST_IDLE is entered at reset. In this state the address holds and step requests are ignored.
- The transition ST_IDLE to ST_ARMED happens on the first load.
- ST_ARMED then persists. A later load in ST_ARMED reloads the register and stays in ST_ARMED.

Only a primitive polynomial gives the full period. Choosing one is the user's responsibility.

Top module: `rlfsr_addr_gen`

## Requirements
- R1: After reset the address is 0, wrap is 0, and the block is unarmed: step requests change nothing until the first load.
- R2: A load captures the seed as the address and the tap mask as the new polynomial, both in the next cycle. A load wins over a simultaneous step. For example, with W=4, mask 3'b001 and seed 4'b0001, forward steps give 0011, 0111, 1111, 1110.
- R3: A forward step (dir_i=0) sets the address to {a[W-2:0], f}. Here f is the XOR of a[W-1], the XOR of the bits a[i] (i<W-1) whose tap mask bit i is 1, and the value 1 when a[W-2:0] is all zero. So 10..0 steps to 00..0, and 00..0 steps to 00..01.
- R4: A backward step (dir_i=1) sets the address to {g, a[W-1:1]}, where g is chosen so that one forward step from the result returns a.
- R5: With a primitive mask, 2^W forward steps from any seed visit every address exactly once. For example, with W=4, mask 3'b100 and seed 0001 the order is 0001, 0010, 0100, 1001, 0011, 0110, 1101, 1010, 0101, 1011, 0111, 1111, 1110, 1100, 1000, 0000.
- R6: Backward steps from the seed produce the forward order exactly reversed.
- R7: wrap_o is 1 for exactly the one cycle after a step that lands the address on the last loaded seed, in either direction. It is 0 at all other times, including after a load.
- R8: Without load or an accepted step, the address and the captured mask hold, and dir_i has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture seed and tap mask |
| seed_i | input | ADDR_W | Starting address, also the wrap reference |
| taps_i | input | ADDR_W-1 | Tap mask for stages 0..ADDR_W-2; the last stage always feeds back |
| step_i | input | 1 | Advance one position |
| dir_i | input | 1 | 0 forward, 1 backward |
| addr_o | output | ADDR_W | Current address |
| wrap_o | output | 1 | Pulse when a step returns to the seed |

## Verification
Every cycle the assertions check the following:
- a load lands its seed;
- a forward step is a left shift and a backward step is a right shift of the previous address;
- the 10..0 state steps into zero;
- an idle cycle leaves the address untouched;
- a wrap pulse appears only on the seed and only after a step.

Some behaviour depends on the feedback polynomial as a whole, and only the bench's scenarios can show it:
- one full period visits every address once;
- the backward walk retraces the forward order;
- a direction change partway through brings the wrap back early;
- a different mask gives a different order.

// File: rtl/rlfsr_pkg.sv
package rlfsr_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } rlfsr_state_e;

    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_BWD = 1'b1
    } rlfsr_dir_e;

endpackage

// File: rtl/rlfsr_step.sv
// One combinational step of the spliced LFSR; REVERSE selects the inverse map.
module rlfsr_step #(
    parameter int W       = 8,
    parameter bit REVERSE = 1'b0
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-2:0] taps_i,
    output logic [W-1:0] nxt_o
);

    localparam int BODY_W = W - 1;

    logic [BODY_W-1:0] body;
    logic              end_bit;
    logic              splice;

    generate
        if (REVERSE == 1'b0) begin : g_fwd
            // body is what survives the shift; end_bit is the leaving MSB
            assign body    = cur_i[W-2:0];
            assign end_bit = cur_i[W-1];
            assign splice  = ~|body;
            assign nxt_o   = {body, end_bit ^ (^(body & taps_i)) ^ splice};
        end else begin : g_bwd
            // body is the surviving upper part; end_bit is the old feedback bit
            assign body    = cur_i[W-1:1];
            assign end_bit = cur_i[0];
            assign splice  = ~|body;
            assign nxt_o   = {end_bit ^ (^(body & taps_i)) ^ splice, body};
        end
    endgenerate

endmodule

// File: rtl/rlfsr_ctrl.sv
// Arming state machine: steps are only honoured once a polynomial is loaded.
module rlfsr_ctrl
    import rlfsr_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    input  logic step_i,
    output logic cap_o,
    output logic adv_o,
    output logic armed_o
);

    rlfsr_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (load_i) state_d = ST_ARMED;
            ST_ARMED: state_d = ST_ARMED;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cap_o   = load_i;
        adv_o   = 1'b0;
        armed_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  adv_o = 1'b0;
            ST_ARMED: begin
                armed_o = 1'b1;
                adv_o   = step_i && !load_i;
            end
            default:  adv_o = 1'b0;
        endcase
    end

    AST_ARM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_ARMED) |=> (state_q == ST_ARMED)); // R2

    AST_LOAD_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> armed_o); // R2

endmodule

// File: rtl/rlfsr_addr_gen.sv
module rlfsr_addr_gen
    import rlfsr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] seed_i,
    input  logic [ADDR_W-2:0] taps_i,
    input  logic              step_i,
    input  logic              dir_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wrap_o
);

    localparam logic [ADDR_W-1:0] TOP_ONLY = {1'b1, {(ADDR_W-1){1'b0}}};

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] anchor_q;
    logic [ADDR_W-2:0] taps_q;
    logic              wrap_q;
    logic [ADDR_W-1:0] fwd_nxt;
    logic [ADDR_W-1:0] bwd_nxt;
    logic [ADDR_W-1:0] sel_nxt;
    logic              cap;
    logic              adv;
    logic              armed;

    rlfsr_ctrl u_ctrl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (load_i),
        .step_i  (step_i),
        .cap_o   (cap),
        .adv_o   (adv),
        .armed_o (armed)
    );

    rlfsr_step #(.W(ADDR_W), .REVERSE(1'b0)) u_fwd (
        .cur_i  (addr_q),
        .taps_i (taps_q),
        .nxt_o  (fwd_nxt)
    );

    rlfsr_step #(.W(ADDR_W), .REVERSE(1'b1)) u_bwd (
        .cur_i  (addr_q),
        .taps_i (taps_q),
        .nxt_o  (bwd_nxt)
    );

    assign sel_nxt = (rlfsr_dir_e'(dir_i) == DIR_BWD) ? bwd_nxt : fwd_nxt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            addr_q   <= '0;
            anchor_q <= '0;
            taps_q   <= '0;
            wrap_q   <= 1'b0;
        end else if (cap) begin
            addr_q   <= seed_i;
            anchor_q <= seed_i;
            taps_q   <= taps_i;
            wrap_q   <= 1'b0;
        end else if (adv) begin
            addr_q   <= sel_nxt;
            wrap_q   <= (sel_nxt == anchor_q);
        end else begin
            wrap_q   <= 1'b0;
        end
    end

    assign addr_o = addr_q;
    assign wrap_o = wrap_q;

    AST_LOAD_SEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (addr_o == $past(seed_i))); // R2

    AST_FWD_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && step_i && armed && !dir_i)
        |=> (addr_o[ADDR_W-1:1] == $past(addr_o[ADDR_W-2:0]))); // R3

    AST_ZERO_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && step_i && armed && !dir_i && addr_o == TOP_ONLY)
        |=> (addr_o == '0)); // R3

    AST_BWD_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && step_i && armed && dir_i)
        |=> (addr_o[ADDR_W-2:0] == $past(addr_o[ADDR_W-1:1]))); // R4

    AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !(step_i && armed)) |=> $stable(addr_o)); // R8

    AST_WRAP_ON_SEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_o |-> (addr_o == anchor_q)); // R7

    AST_WRAP_AFTER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_o |-> ($past(step_i) && !$past(load_i))); // R7

endmodule

// File: tb/rlfsr_addr_gen_tb_top.sv
module rlfsr_addr_gen_tb_top;

    localparam int W = 4;
    localparam int N = 1 << W;

    // R5 reference order for mask 3'b100, seed 0001
    localparam logic [W-1:0] SEQ [N] = '{
        4'b0001, 4'b0010, 4'b0100, 4'b1001, 4'b0011, 4'b0110, 4'b1101, 4'b1010,
        4'b0101, 4'b1011, 4'b0111, 4'b1111, 4'b1110, 4'b1100, 4'b1000, 4'b0000
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic [W-1:0] seed = '0;
    logic [W-2:0] taps = '0;
    logic         step = 1'b0;
    logic         dir = 1'b0;
    logic [W-1:0] addr;
    logic         wrap;

    int nvec = 0;
    int nerr = 0;
    logic [N-1:0] seen;

    always #5 clk = ~clk;

    rlfsr_addr_gen #(.ADDR_W(W)) dut_i (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .load_i (load),
        .seed_i (seed),
        .taps_i (taps),
        .step_i (step),
        .dir_i  (dir),
        .addr_o (addr),
        .wrap_o (wrap)
    );

    task automatic check_out(input string req, input logic [W-1:0] ea, input logic ew);
        nvec++;
        if (addr !== ea || wrap !== ew) begin
            nerr++;
            $display("FAIL %s: addr=%b wrap=%b expected addr=%b wrap=%b", req, addr, wrap, ea, ew);
        end
    endtask

    task automatic do_step(input logic d);
        @(negedge clk);
        step = 1'b1;
        dir  = d;
        @(negedge clk);
        step = 1'b0;
    endtask

    task automatic do_load(input logic [W-1:0] s, input logic [W-2:0] t, input logic with_step);
        @(negedge clk);
        load = 1'b1;
        seed = s;
        taps = t;
        step = with_step;
        dir  = 1'b0;
        @(negedge clk);
        load = 1'b0;
        step = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: run did not complete, expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1 reset state", '0, 1'b0);

        // R1: step before any load is ignored
        do_step(1'b0);
        check_out("R1 step while unarmed", '0, 1'b0);

        do_load(4'b0001, 3'b100, 1'b0);
        check_out("R2 load seed", 4'b0001, 1'b0);

        // R3 R5 R7: forward period walked from the table
        seen = '0;
        seen[addr] = 1'b1;
        for (int k = 1; k <= N; k++) begin
            do_step(1'b0);
            check_out("R3 R5 forward order", SEQ[k % N], (k == N));
            if (k < N) begin
                nvec++;
                if (seen[addr]) begin
                    nerr++;
                    $display("FAIL R5 repeat visit: addr=%b seen=1 expected seen=0", addr);
                end
                seen[addr] = 1'b1;
            end
        end
        nvec++;
        if (seen !== {N{1'b1}}) begin
            nerr++;
            $display("FAIL R5 coverage: seen=%b expected %b", seen, {N{1'b1}});
        end

        // R4 R6: backward period retraces the table in reverse
        for (int j = 1; j <= N; j++) begin
            do_step(1'b1);
            check_out("R4 R6 reverse order", SEQ[(N - j) % N], (j == N));
        end

        // R8: idle cycles with dir toggling change nothing
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            dir = ~dir;
        end
        @(negedge clk);
        check_out("R8 hold with dir toggling", 4'b0001, 1'b0);

        // R7 R4: three forward then three back returns to seed early
        do_step(1'b0);
        do_step(1'b0);
        do_step(1'b0);
        check_out("R3 three forward", 4'b1001, 1'b0);
        do_step(1'b1);
        check_out("R4 back one", 4'b0100, 1'b0);
        do_step(1'b1);
        do_step(1'b1);
        check_out("R7 wrap after direction change", 4'b0001, 1'b1);
        @(negedge clk);
        check_out("R7 wrap is one cycle", 4'b0001, 1'b0);

        // R2: load wins over simultaneous step
        do_load(4'b1000, 3'b100, 1'b1);
        check_out("R2 load priority", 4'b1000, 1'b0);
        do_step(1'b0);
        check_out("R3 splice 1000 to 0000", 4'b0000, 1'b0);
        do_step(1'b0);
        check_out("R3 splice 0000 to 0001", 4'b0001, 1'b0);
        do_step(1'b1);
        check_out("R4 reverse into zero", 4'b0000, 1'b0);
        do_step(1'b1);
        check_out("R7 reverse lands on seed", 4'b1000, 1'b1);

        // R2: new mask changes the order
        do_load(4'b0001, 3'b001, 1'b0);
        check_out("R2 reload", 4'b0001, 1'b0);
        do_step(1'b0);
        check_out("R2 mask 001 step1", 4'b0011, 1'b0);
        do_step(1'b0);
        check_out("R2 mask 001 step2", 4'b0111, 1'b0);
        do_step(1'b0);
        check_out("R2 mask 001 step3", 4'b1111, 1'b0);
        do_step(1'b0);
        check_out("R2 mask 001 step4", 4'b1110, 1'b0);

        // R1: reset mid-run clears and disarms
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1 reset mid-run", '0, 1'b0);
        do_step(1'b0);
        check_out("R1 unarmed after reset", '0, 1'b0);

        summary();
        $finish;
    end

endmodule